// File: doc/BRIEF.md
# Load Wait Predictor

This block keeps one bit per load instruction address that remembers whether that load once ran ahead of an older store to the same memory location. The load/store queue finds such ordering violations by comparing addresses and reports the offending load's PC. The block then sets the bit indexed by that PC. When the same load is later dispatched, it looks up its bit. A set bit marks the load as one that must wait for every older store to issue first. The block does not try to name the one store the load depends on.

The issue queue keeps the wait flag with each load. For every load it supplies a mask of the older stores that have not yet issued. From the flag and the mask the block computes a hold signal for that load. Register renaming cannot catch this kind of dependence, because the address is only known after the instructions issue. A free-running timer clears the whole table at a fixed period, so that old predictions expire and the table does not fill with set bits.

Top module: `ld_wait_pred`

## Requirements
- R1: After reset every table bit is clear, so every valid lookup returns 0 on `lk_wait`.
- R2: A lookup port with `lk_vld` high drives its `lk_wait` combinationally from the table bit at index `lk_pc[11:2]` (the default of 1024 entries, with word-aligned PCs).
- R3: A violation report (`tr_vld` high with `tr_pc`) sets the bit at `tr_pc[11:2]`. The set bit is visible from the cycle after the report. A lookup of the same index in the report cycle still returns the old value.
- R4: A report changes only its own entry. Entries at other indices keep their values.
- R5: `hq_hold[j]` is high exactly when `hq_wait[j]` is high and at least one bit of slot j's 16-bit mask of unissued older stores (`hq_older[16*j +: 16]`) is set. The slots are independent of each other.
- R6: The whole table is cleared at the CLR_PERIOD-th rising edge after reset is released, and again at every CLR_PERIOD-th edge after that.
- R7: A report that arrives in the same cycle as a periodic clear survives the clear. Its bit reads 1 after that edge, and every other bit reads 0.
- R8: A lookup port with `lk_vld` low drives `lk_wait` to 0, whatever the table holds.
- R9: Two PCs that agree in bits [11:2] share one entry. Training one of them makes the other read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | NLK | Dispatch lookup valid, one per port |
| lk_pc | input | NLK*PC_W | Load PC for each lookup port |
| lk_wait | output | NLK | Predicted-dependent flag for each lookup port |
| tr_vld | input | 1 | Ordering violation report valid |
| tr_pc | input | PC_W | PC of the load that violated ordering |
| hq_wait | input | NHQ | Stored wait flag for each issue-queue load slot |
| hq_older | input | NHQ*SQ_N | Per slot: mask of older stores not yet issued |
| hq_hold | output | NHQ | Per slot: load must not issue this cycle |

## Verification
The lookup outputs and the hold outputs are combinational. The bench therefore drives them on a falling edge and reads them one time unit later, in the same cycle. A training write needs one rising edge. It is checked first in its report cycle, where the old value is expected, and again on the next falling edge, where the new value is expected. The bench counts rising edges since reset release, using the same rule the design uses. It stops on the falling edge just before edge CLR_PERIOD, checks the table there, and checks it again after that edge.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

   typedef enum logic {
      LDW_TRAIN_WINS = 1'b0,
      LDW_CLEAR_WINS = 1'b1
   } ldw_prio_e;

endpackage

// File: rtl/ldw_table.sv
module ldw_table
   import ldw_pkg::*;
#(
   parameter int unsigned ENTRIES = 1024,
   parameter int unsigned NRD     = 2,
   parameter ldw_prio_e   PRIO    = LDW_TRAIN_WINS,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NRD*IDX_W-1:0] rd_idx,
   output logic [NRD-1:0]       rd_bit,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic                 clr
);

   logic [ENTRIES-1:0] bits_q;
   logic [ENTRIES-1:0] bits_d;

   generate
      if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("ldw_table: ENTRIES must be a power of two");
      end

      if (PRIO == LDW_TRAIN_WINS) begin : g_train_wins
         always_comb begin
            bits_d = clr ? '0 : bits_q;
            if (wr_en) bits_d[wr_idx] = 1'b1;
         end
      end else begin : g_clear_wins
         always_comb begin
            bits_d = bits_q;
            if (clr)        bits_d = '0;
            else if (wr_en) bits_d[wr_idx] = 1'b1;
         end
      end

      for (genvar k = 0; k < NRD; k++) begin : g_rd
         assign rd_bit[k] = bits_q[rd_idx[k*IDX_W +: IDX_W]];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
   end

   // R3 / R7: a report is visible on the following cycle
   p_train_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (PRIO == LDW_TRAIN_WINS || !clr)) |=> bits_q[$past(wr_idx)]);

   // R6: a clear without a report empties the table
   p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> (bits_q == '0));

   // R4: without a report no bit can become set
   p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($countones(bits_q) <= $countones($past(bits_q))));

endmodule

// File: rtl/ldw_age_timer.sv
module ldw_age_timer #(
   parameter int unsigned PERIOD = 16384,
   localparam int unsigned CNT_W = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   output logic clr
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("ldw_age_timer: PERIOD must be at least 2");
      end
   endgenerate

   assign clr = (cnt_q == CNT_W'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   // R6: the count stays inside one period
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cnt_q) < PERIOD));

   // R6: a clear pulse starts a new period
   p_clr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/ldw_hold.sv
module ldw_hold #(
   parameter int unsigned NHQ  = 4,
   parameter int unsigned SQ_N = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NHQ-1:0]      hq_wait,
   input  logic [NHQ*SQ_N-1:0] hq_older,
   output logic [NHQ-1:0]      hq_hold
);

   generate
      if (NHQ < 1 || SQ_N < 1) begin : g_bad_dims
         $error("ldw_hold: NHQ and SQ_N must be non-zero");
      end

      for (genvar j = 0; j < NHQ; j++) begin : g_slot
         assign hq_hold[j] = hq_wait[j] && (hq_older[j*SQ_N +: SQ_N] != '0);

         // R5: with no older store pending, the load is released
         p_hold_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hq_older[j*SQ_N +: SQ_N] == '0) |-> !hq_hold[j]);
      end
   endgenerate

endmodule

// File: rtl/ld_wait_pred.sv
module ld_wait_pred
   import ldw_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned PC_LSB     = 2,
   parameter int unsigned ENTRIES    = 1024,
   parameter int unsigned NLK        = 2,
   parameter int unsigned NHQ        = 4,
   parameter int unsigned SQ_N       = 16,
   parameter int unsigned CLR_PERIOD = 16384,
   parameter ldw_prio_e   PRIO       = LDW_TRAIN_WINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NLK-1:0]      lk_vld,
   input  logic [NLK*PC_W-1:0] lk_pc,
   output logic [NLK-1:0]      lk_wait,
   input  logic                tr_vld,
   input  logic [PC_W-1:0]     tr_pc,
   input  logic [NHQ-1:0]      hq_wait,
   input  logic [NHQ*SQ_N-1:0] hq_older,
   output logic [NHQ-1:0]      hq_hold
);

   localparam int unsigned IDX_W = $clog2(ENTRIES);

   generate
      if (PC_LSB + IDX_W > PC_W) begin : g_bad_pc
         $error("ld_wait_pred: PC too narrow for table index");
      end
   endgenerate

   logic [NLK*IDX_W-1:0] rd_idx;
   logic [NLK-1:0]       rd_bit;
   logic                 age_clr;

   generate
      for (genvar k = 0; k < NLK; k++) begin : g_lk
         assign rd_idx[k*IDX_W +: IDX_W] = lk_pc[k*PC_W + PC_LSB +: IDX_W];
         assign lk_wait[k]               = lk_vld[k] && rd_bit[k];

         // R8: an idle lookup port never asks a load to wait
         p_idle_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !lk_vld[k] |-> !lk_wait[k]);
      end
   endgenerate

   ldw_table #(
      .ENTRIES (ENTRIES),
      .NRD     (NLK),
      .PRIO    (PRIO)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rd_idx),
      .rd_bit (rd_bit),
      .wr_en  (tr_vld),
      .wr_idx (tr_pc[PC_LSB +: IDX_W]),
      .clr    (age_clr)
   );

   ldw_age_timer #(
      .PERIOD (CLR_PERIOD)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (age_clr)
   );

   ldw_hold #(
      .NHQ  (NHQ),
      .SQ_N (SQ_N)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hq_wait  (hq_wait),
      .hq_older (hq_older),
      .hq_hold  (hq_hold)
   );

endmodule

// File: tb/ld_wait_pred_tb.sv
module ld_wait_pred_tb;

   localparam int unsigned PC_W   = 32;
   localparam int unsigned NLK    = 2;
   localparam int unsigned NHQ    = 4;
   localparam int unsigned SQ_N   = 16;
   localparam int unsigned PERIOD = 256;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NLK-1:0]      lk_vld = '0;
   logic [NLK*PC_W-1:0] lk_pc = '0;
   logic [NLK-1:0]      lk_wait;
   logic                tr_vld = 1'b0;
   logic [PC_W-1:0]     tr_pc = '0;
   logic [NHQ-1:0]      hq_wait = '0;
   logic [NHQ*SQ_N-1:0] hq_older = '0;
   logic [NHQ-1:0]      hq_hold;

   int n_chk  = 0;
   int n_bad  = 0;
   int edges  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   ld_wait_pred #(.CLR_PERIOD(PERIOD)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_vld   (lk_vld),
      .lk_pc    (lk_pc),
      .lk_wait  (lk_wait),
      .tr_vld   (tr_vld),
      .tr_pc    (tr_pc),
      .hq_wait  (hq_wait),
      .hq_older (hq_older),
      .hq_hold  (hq_hold)
   );

   always @(posedge clk) begin
      if (rst_n) edges <= edges + 1;
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, got %0d cycles, expected fewer than 20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input logic got, input logic exp, input string tag);
      n_chk = n_chk + 1;
      if (got !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // drive a lookup on one port and read the result in the same cycle
   task automatic look(input int port, input logic [PC_W-1:0] pc, output logic w);
      lk_vld[port] = 1'b1;
      lk_pc[port*PC_W +: PC_W] = pc;
      #1;
      w = lk_wait[port];
      lk_vld[port] = 1'b0;
   endtask

   task automatic train(input logic [PC_W-1:0] pc);
      @(negedge clk);
      tr_vld = 1'b1;
      tr_pc  = pc;
      @(negedge clk);
      tr_vld = 1'b0;
   endtask

   task automatic t_reset();
      logic w;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         look(i % 2, 32'h1000 + 32'(i * 4), w);
         check(w, 1'b0, "R1 reset lookup");
      end
   endtask

   task automatic t_train();
      logic w;
      @(negedge clk);
      tr_vld = 1'b1;
      tr_pc  = 32'h0000_0040;
      look(0, 32'h0000_0040, w);
      check(w, 1'b0, "R3 same-cycle lookup sees old value");
      @(negedge clk);
      tr_vld = 1'b0;
      look(0, 32'h0000_0040, w);
      check(w, 1'b1, "R3 trained bit visible next cycle");
      look(1, 32'h0000_0040, w);
      check(w, 1'b1, "R2 second lookup port reads same entry");
   endtask

   task automatic t_idle();
      @(negedge clk);
      lk_vld = '0;
      lk_pc  = {32'h0000_0040, 32'h0000_0040};
      #1;
      check(lk_wait[0], 1'b0, "R8 idle port 0");
      check(lk_wait[1], 1'b0, "R8 idle port 1");
   endtask

   task automatic t_isolation();
      logic w;
      look(0, 32'h0000_003C, w);
      check(w, 1'b0, "R4 lower neighbour untouched");
      look(1, 32'h0000_0044, w);
      check(w, 1'b0, "R4 upper neighbour untouched");
      look(0, 32'h0000_0041, w);
      check(w, 1'b1, "R2 byte offset bits ignored in index");
      train(32'h0000_0FFC);
      look(0, 32'h0000_0FFC, w);
      check(w, 1'b1, "R2 top index trained");
      look(1, 32'h0000_0040, w);
      check(w, 1'b1, "R4 earlier entry kept");
      look(0, 32'h0000_0000, w);
      check(w, 1'b0, "R4 entry 0 untouched");
   endtask

   task automatic t_alias();
      logic w;
      train(32'h0001_2208);
      look(0, 32'h0000_0208, w);
      check(w, 1'b1, "R9 alias on bits 11:2");
      look(1, 32'hFFFF_F208, w);
      check(w, 1'b1, "R9 alias high bits");
      look(0, 32'h0001_220C, w);
      check(w, 1'b0, "R9 different index not aliased");
   endtask

   task automatic t_hold();
      @(negedge clk);
      hq_wait  = 4'b1111;
      hq_older = '0;
      #1;
      for (int j = 0; j < NHQ; j++) check(hq_hold[j], 1'b0, "R5 no older store");
      @(negedge clk);
      hq_older[2*SQ_N + 15] = 1'b1;
      #1;
      check(hq_hold[2], 1'b1, "R5 top older bit holds slot 2");
      check(hq_hold[1], 1'b0, "R5 slot 1 independent");
      check(hq_hold[3], 1'b0, "R5 slot 3 independent");
      @(negedge clk);
      hq_wait  = 4'b1011;
      hq_older = {16'h0001, 16'h8000, 16'h0000, 16'h0100};
      #1;
      check(hq_hold[0], 1'b1, "R5 slot 0 held");
      check(hq_hold[1], 1'b0, "R5 slot 1 empty mask");
      check(hq_hold[2], 1'b0, "R5 slot 2 not flagged");
      check(hq_hold[3], 1'b1, "R5 slot 3 held");
      @(negedge clk);
      hq_wait  = '0;
      hq_older = '0;
   endtask

   task automatic t_clear();
      logic w;
      train(32'h0000_0100);
      while ((edges % PERIOD) != (PERIOD - 1)) @(negedge clk);
      look(0, 32'h0000_0100, w);
      check(w, 1'b1, "R6 bit set just before clear edge");
      tr_vld = 1'b1;
      tr_pc  = 32'h0000_0200;
      @(negedge clk);
      tr_vld = 1'b0;
      look(0, 32'h0000_0100, w);
      check(w, 1'b0, "R6 bit cleared at period edge");
      look(1, 32'h0000_0040, w);
      check(w, 1'b0, "R6 older bit cleared");
      look(0, 32'h0000_0200, w);
      check(w, 1'b1, "R7 report in clear cycle survives");
      train(32'h0000_0300);
      while ((edges % PERIOD) != (PERIOD - 1)) @(negedge clk);
      look(1, 32'h0000_0300, w);
      check(w, 1'b1, "R6 bit held through second period");
      @(negedge clk);
      look(1, 32'h0000_0300, w);
      check(w, 1'b0, "R6 second period clear");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_train();
      t_idle();
      t_isolation();
      t_alias();
      t_hold();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule